// File: doc/BRIEF.md
# Width-Configurable Integer ALU

This block is the integer execution slice of a processor datapath whose register width is chosen at elaboration as 32 or 64 bits. It accepts one request per cycle and returns the result one cycle later. Each request carries two register operands, an immediate that has already been sign-extended to the full width, a 4-bit operation code and the raw 6-bit shift-amount field taken from instruction bits 25:20. The block covers addition, subtraction, bitwise logic and shifts. In the 64-bit build it also covers the word operations, which work on the low 32 bits and return a sign-extended 32-bit value.

How shift amounts are masked and checked depends on the configured width. A request that cannot be executed is not written back. It still produces a result strobe, but with the illegal flag set and a zero result. This happens for an oversized immediate left shift on the 32-bit build, for a word operation on the 32-bit build, and for the reserved code.

Top module: `xlen_alu`

## Requirements
- R1: `res_valid` is high in the cycle after each cycle with `req_valid` high, and low in the cycle after each cycle with `req_valid` low. Results come out in request order.
- R2: ADD (code 0) returns a+b, SUB (code 1) returns a−b, and ADDI (code 5) returns a+imm. All three wrap modulo 2^XLEN.
- R3: AND (code 2), OR (code 3) and XOR (code 4) return the bitwise function of the two operands.
- R4: SLL (code 6), SRL (code 7) and SRA (code 8) shift `opnd_a` by the low log2(XLEN) bits of `opnd_b`: 5 bits at XLEN=32, 6 bits at XLEN=64. The remaining bits of `opnd_b` are ignored.
- R5: Arithmetic right shifts fill with copies of bit XLEN−1 of the full-width operand. Logical right shifts fill with zeros.
- R6: SLLI (code 9), SRLI (code 10) and SRAI (code 11) take the shift amount from `shamt_fld`. At XLEN=64 all six bits are used and no value is illegal.
- R7: At XLEN=32, SLLI with `shamt_fld[5]` set (amount 32 or more) sets `res_illegal` and returns zero. SRLI and SRAI use only `shamt_fld[4:0]`.
- R8: At XLEN=64, ADDW (code 12) and SUBW (code 13) compute the sum or difference, keep bits 31:0, and sign-extend bit 31 into bits 63:32.
- R9: At XLEN=64, ADDIW (code 14) adds the low 32 bits of `imm_val` to the low 32 bits of `opnd_a` and sign-extends the 32-bit sum.
- R10: At XLEN=32, codes 12, 13 and 14 set `res_illegal` and return zero.
- R11: Code 15 is reserved. At both widths it sets `res_illegal` and returns zero.
- R12: While reset is held, `res_valid`, `res_illegal` and `res_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| op_sel | input | 4 | Operation code |
| opnd_a | input | XLEN | First source operand |
| opnd_b | input | XLEN | Second source operand; its low bits give the register shift amount |
| imm_val | input | XLEN | Sign-extended immediate |
| shamt_fld | input | 6 | Raw immediate shift-amount field (instruction bits 25:20) |
| res_valid | output | 1 | Result strobe, one cycle after the request |
| res_data | output | XLEN | Registered result, zero when illegal |
| res_illegal | output | 1 | Illegal-instruction flag, valid with `res_valid` |

## Verification
The bench builds two instances side by side, one with XLEN=64 and one with XLEN=32, and sends the same request stream to both. The 32-bit instance receives the low halves of the operands. Running the same stimulus through both widths makes the width-dependent cases directly comparable. A shift amount with bit 5 set is honoured by one instance and masked or flagged by the other. A word operation returns a sign-extended value on one and raises the illegal flag on the other. A negative operand shows sign fill relative to each build's own top bit.

// File: rtl/xalu_pkg.sv
package xalu_pkg;

   // Operation codes; the numeric values are part of the interface.
   typedef enum logic [3:0] {
      EX_ADD   = 4'd0,
      EX_SUB   = 4'd1,
      EX_AND   = 4'd2,
      EX_OR    = 4'd3,
      EX_XOR   = 4'd4,
      EX_ADDI  = 4'd5,
      EX_SLL   = 4'd6,
      EX_SRL   = 4'd7,
      EX_SRA   = 4'd8,
      EX_SLLI  = 4'd9,
      EX_SRLI  = 4'd10,
      EX_SRAI  = 4'd11,
      EX_ADDW  = 4'd12,
      EX_SUBW  = 4'd13,
      EX_ADDIW = 4'd14,
      EX_RSVD  = 4'd15
   } ex_op_e;

   typedef enum logic [1:0] {
      SH_LEFT  = 2'd0,
      SH_LOGIC = 2'd1,
      SH_ARITH = 2'd2
   } sh_kind_e;

   // Width of the raw immediate shift-amount field.
   localparam int SHAMT_FLD_W = 6;

   // Width of the word operations.
   localparam int WORD_W = 32;

endpackage

// File: rtl/xlen_alu_shift.sv
module xlen_alu_shift
   import xalu_pkg::*;
#(
   parameter int XLEN = 64,
   localparam int SHW = $clog2(XLEN)
) (
   input  logic [XLEN-1:0] din,
   input  logic [SHW-1:0]  amt,
   input  sh_kind_e        kind,
   output logic [XLEN-1:0] dout
);

   if ((1 << SHW) != XLEN) begin : g_chk_pow2
      $error("xlen_alu_shift: XLEN must be a power of two");
   end

   always_comb begin
      unique case (kind)
         SH_LEFT:  dout = din << amt;
         SH_LOGIC: dout = din >> amt;
         default:  dout = $unsigned($signed(din) >>> amt);
      endcase
   end

endmodule

// File: rtl/xlen_alu_word.sv
module xlen_alu_word
   import xalu_pkg::*;
#(
   parameter int XLEN = 64,
   localparam int EXT = XLEN - WORD_W
) (
   input  logic [WORD_W-1:0] a_lo,
   input  logic [WORD_W-1:0] b_lo,
   input  logic [WORD_W-1:0] imm_lo,
   input  logic [1:0]        sel,      // 0 add, 1 sub, 2 add immediate
   output logic [XLEN-1:0]   y
);

   if (XLEN <= WORD_W) begin : g_chk_wide
      $error("xlen_alu_word: needs XLEN wider than the word size");
   end

   logic [WORD_W-1:0] w;

   always_comb begin
      unique case (sel)
         2'd1:    w = a_lo - b_lo;
         2'd2:    w = a_lo + imm_lo;
         default: w = a_lo + b_lo;
      endcase
   end

   assign y = {{EXT{w[WORD_W-1]}}, w};

endmodule

// File: rtl/xlen_alu.sv
module xlen_alu
   import xalu_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   input  logic [3:0]      op_sel,
   input  logic [XLEN-1:0] opnd_a,
   input  logic [XLEN-1:0] opnd_b,
   input  logic [XLEN-1:0] imm_val,
   input  logic [5:0]      shamt_fld,
   output logic            res_valid,
   output logic [XLEN-1:0] res_data,
   output logic            res_illegal
);

   localparam int SHW      = $clog2(XLEN);
   localparam bit HAS_WORD = (XLEN == 64);

   if (SHW > SHAMT_FLD_W) begin : g_chk_fld
      $error("xlen_alu: shift field too narrow for XLEN");
   end

   ex_op_e op;
   assign op = ex_op_e'(op_sel);

   logic            imm_shift;
   logic [SHW-1:0]  imm_amt;
   logic [SHW-1:0]  sh_amt;
   logic            slli_bad;
   logic [XLEN-1:0] word_res;
   logic [XLEN-1:0] sh_out;
   sh_kind_e        sh_kind;

   assign imm_shift = (op == EX_SLLI) || (op == EX_SRLI) || (op == EX_SRAI);

   // Width-specific variants: immediate shift masking/legality and word unit
   if (XLEN == 64) begin : g_wide
      logic [1:0] word_sel;

      assign imm_amt  = shamt_fld[SHW-1:0];
      assign slli_bad = 1'b0;
      assign word_sel = (op == EX_SUBW)  ? 2'd1 :
                        (op == EX_ADDIW) ? 2'd2 : 2'd0;

      xlen_alu_word #(.XLEN(XLEN)) word_i (
         .a_lo   (opnd_a[WORD_W-1:0]),
         .b_lo   (opnd_b[WORD_W-1:0]),
         .imm_lo (imm_val[WORD_W-1:0]),
         .sel    (word_sel),
         .y      (word_res)
      );

      AST_WORD_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
         req_valid && (op_sel inside {4'd12, 4'd13, 4'd14}) |=>
            !res_illegal && (res_data[XLEN-1:WORD_W] == {(XLEN-WORD_W){res_data[WORD_W-1]}})); // R8
   end else if (XLEN == 32) begin : g_narrow
      assign imm_amt  = shamt_fld[SHW-1:0];
      assign slli_bad = shamt_fld[SHAMT_FLD_W-1];
      assign word_res = '0;

      AST_WORD_ILLEGAL_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
         req_valid && (op_sel inside {4'd12, 4'd13, 4'd14}) |=> res_illegal && (res_data == '0)); // R10

      AST_SLLI_WIDE_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
         req_valid && (op_sel == 4'd9) && shamt_fld[5] |=> res_illegal && (res_data == '0)); // R7
   end else begin : g_bad_xlen
      $error("xlen_alu: XLEN must be 32 or 64");
      assign imm_amt  = '0;
      assign slli_bad = 1'b1;
      assign word_res = '0;
   end

   assign sh_amt = imm_shift ? imm_amt : opnd_b[SHW-1:0];

   always_comb begin
      unique case (op)
         EX_SLL, EX_SLLI: sh_kind = SH_LEFT;
         EX_SRA, EX_SRAI: sh_kind = SH_ARITH;
         default:         sh_kind = SH_LOGIC;
      endcase
   end

   xlen_alu_shift #(.XLEN(XLEN)) shift_i (
      .din  (opnd_a),
      .amt  (sh_amt),
      .kind (sh_kind),
      .dout (sh_out)
   );

   logic [XLEN-1:0] nxt_data;
   logic            nxt_bad;

   always_comb begin
      nxt_data = '0;
      nxt_bad  = 1'b0;
      unique case (op)
         EX_ADD:  nxt_data = opnd_a + opnd_b;
         EX_SUB:  nxt_data = opnd_a - opnd_b;
         EX_AND:  nxt_data = opnd_a & opnd_b;
         EX_OR:   nxt_data = opnd_a | opnd_b;
         EX_XOR:  nxt_data = opnd_a ^ opnd_b;
         EX_ADDI: nxt_data = opnd_a + imm_val;
         EX_SLL, EX_SRL, EX_SRA, EX_SRLI, EX_SRAI: nxt_data = sh_out;
         EX_SLLI: begin
            nxt_data = sh_out;
            nxt_bad  = slli_bad;
         end
         EX_ADDW, EX_SUBW, EX_ADDIW: begin
            nxt_data = word_res;
            nxt_bad  = !HAS_WORD;
         end
         default: nxt_bad = 1'b1;
      endcase
      if (nxt_bad) begin
         nxt_data = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid   <= 1'b0;
         res_illegal <= 1'b0;
         res_data    <= '0;
      end else begin
         res_valid   <= req_valid;
         res_illegal <= req_valid & nxt_bad;
         if (req_valid) begin
            res_data <= nxt_data;
         end
      end
   end

   AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> res_valid); // R1

   AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !res_valid); // R1

   AST_RSVD_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && (op_sel == 4'd15) |=> res_illegal && (res_data == '0)); // R11

   AST_FLAG_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      res_illegal |-> res_valid); // R1

endmodule

// File: tb/xlen_alu_tb_top.sv
`timescale 1ns/1ps
module xlen_alu_tb_top;

   typedef struct {
      logic        bad;
      logic [63:0] d;
      string       req;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [3:0]  op = '0;
   logic [63:0] a = '0, b = '0, imm = '0;
   logic [5:0]  sh = '0;

   logic        v64, ill64, v32, ill32;
   logic [63:0] d64;
   logic [31:0] d32;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   exp_t q64[$];
   exp_t q32[$];

   always #4 clk = ~clk;   // 125 MHz

   xlen_alu #(.XLEN(64)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op_sel(op),
      .opnd_a(a), .opnd_b(b), .imm_val(imm), .shamt_fld(sh),
      .res_valid(v64), .res_data(d64), .res_illegal(ill64));

   xlen_alu #(.XLEN(32)) dut32_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op_sel(op),
      .opnd_a(a[31:0]), .opnd_b(b[31:0]), .imm_val(imm[31:0]), .shamt_fld(sh),
      .res_valid(v32), .res_data(d32), .res_illegal(ill32));

   function automatic logic [63:0] sx32(input logic [31:0] x);
      return {{32{x[31]}}, x};
   endfunction

   function automatic void model64(input logic [3:0] o, input logic [63:0] x, y, im,
                                   input logic [5:0] s, output logic bad, output logic [63:0] r);
      logic [31:0] w;
      bad = 1'b0; r = '0;
      case (o)
         4'd0:  r = x + y;
         4'd1:  r = x - y;
         4'd2:  r = x & y;
         4'd3:  r = x | y;
         4'd4:  r = x ^ y;
         4'd5:  r = x + im;
         4'd6:  r = x << y[5:0];
         4'd7:  r = x >> y[5:0];
         4'd8:  r = $unsigned($signed(x) >>> y[5:0]);
         4'd9:  r = x << s;
         4'd10: r = x >> s;
         4'd11: r = $unsigned($signed(x) >>> s);
         4'd12: begin w = x[31:0] + y[31:0];  r = sx32(w); end
         4'd13: begin w = x[31:0] - y[31:0];  r = sx32(w); end
         4'd14: begin w = x[31:0] + im[31:0]; r = sx32(w); end
         default: bad = 1'b1;
      endcase
   endfunction

   function automatic void model32(input logic [3:0] o, input logic [31:0] x, y, im,
                                   input logic [5:0] s, output logic bad, output logic [63:0] r);
      logic [31:0] t;
      bad = 1'b0; t = '0;
      case (o)
         4'd0:  t = x + y;
         4'd1:  t = x - y;
         4'd2:  t = x & y;
         4'd3:  t = x | y;
         4'd4:  t = x ^ y;
         4'd5:  t = x + im;
         4'd6:  t = x << y[4:0];
         4'd7:  t = x >> y[4:0];
         4'd8:  t = $unsigned($signed(x) >>> y[4:0]);
         4'd9:  if (s[5]) bad = 1'b1; else t = x << s[4:0];
         4'd10: t = x >> s[4:0];
         4'd11: t = $unsigned($signed(x) >>> s[4:0]);
         default: bad = 1'b1;   // word ops and reserved code
      endcase
      r = {32'd0, t};
   endfunction

   function automatic string tag_of(input logic [3:0] o, input bit narrow);
      case (o)
         4'd0, 4'd1, 4'd5:    return "R2";
         4'd2, 4'd3, 4'd4:    return "R3";
         4'd6, 4'd7, 4'd8:    return "R4";
         4'd9, 4'd10, 4'd11:  return narrow ? "R7" : "R6";
         4'd12, 4'd13:        return narrow ? "R10" : "R8";
         4'd14:               return narrow ? "R10" : "R9";
         default:             return "R11";
      endcase
   endfunction

   // Driver: one request per call, expectations pushed to both scoreboards
   task automatic send(input logic [3:0] o, input logic [63:0] x, y, im,
                       input logic [5:0] s, input string rq);
      exp_t e64, e32;
      @(negedge clk);
      op = o; a = x; b = y; imm = im; sh = s; req_valid = 1'b1;
      model64(o, x, y, im, s, e64.bad, e64.d);
      model32(o, x[31:0], y[31:0], im[31:0], s, e32.bad, e32.d);
      e64.req = (rq == "") ? tag_of(o, 1'b0) : rq;
      e32.req = (rq == "") ? tag_of(o, 1'b1) : rq;
      q64.push_back(e64);
      q32.push_back(e32);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         req_valid = 1'b0;
      end
   endtask

   // Monitor: pop and compare at the falling edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (v64) begin
            checks++;
            if (q64.size() == 0) begin
               errors++;
               $display("FAIL R1 w64: actual unexpected strobe, expected none");
            end else begin
               exp_t e;
               e = q64.pop_front();
               if (ill64 !== e.bad || d64 !== e.d) begin
                  errors++;
                  $display("FAIL %s w64: actual ill=%0b data=%h expected ill=%0b data=%h",
                           e.req, ill64, d64, e.bad, e.d);
               end
            end
         end
         if (v32) begin
            checks++;
            if (q32.size() == 0) begin
               errors++;
               $display("FAIL R1 w32: actual unexpected strobe, expected none");
            end else begin
               exp_t e;
               e = q32.pop_front();
               if (ill32 !== e.bad || {32'd0, d32} !== e.d) begin
                  errors++;
                  $display("FAIL %s w32: actual ill=%0b data=%h expected ill=%0b data=%h",
                           e.req, ill32, d32, e.bad, e.d[31:0]);
               end
            end
         end
      end
   end

   task automatic finish_run();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin : watchdog
      #(8 * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout, expected completion");
         finish_run();
      end
   end

   initial begin : stim
      // R12: reset state
      #3;
      checks++;
      if (v64 !== 1'b0 || ill64 !== 1'b0 || d64 !== 64'd0 ||
          v32 !== 1'b0 || ill32 !== 1'b0 || d32 !== 32'd0) begin
         errors++;
         $display("FAIL R12: actual v=%0b/%0b ill=%0b/%0b data=%h/%h expected all zero",
                  v64, v32, ill64, ill32, d64, d32);
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle(2);

      // R2: add, subtract, add-immediate, with wrap
      send(4'd0, 64'd5, 64'd7, 64'd0, 6'd0, "R2");
      send(4'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd0, 6'd0, "R2");
      send(4'd1, 64'd3, 64'd5, 64'd0, 6'd0, "R2");
      send(4'd5, 64'h1234_5678_9ABC_DEF0, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 6'd0, "R2");
      idle(1);
      // R3: logic
      send(4'd2, 64'hF0F0_0FF0_AAAA_5555, 64'h0FF0_FF00_FFFF_0000, 64'd0, 6'd0, "R3");
      send(4'd3, 64'hF0F0_0FF0_AAAA_5555, 64'h0FF0_FF00_FFFF_0000, 64'd0, 6'd0, "R3");
      send(4'd4, 64'hF0F0_0FF0_AAAA_5555, 64'h0FF0_FF00_FFFF_0000, 64'd0, 6'd0, "R3");
      // R4: register shift amount masked (0x25 -> 37 wide, 5 narrow; 0x41 -> 1)
      send(4'd6, 64'd1, 64'h0000_0000_0000_0025, 64'd0, 6'd0, "R4");
      send(4'd6, 64'h3, 64'hFFFF_FFFF_FFFF_FFC1, 64'd0, 6'd0, "R4");
      // R5: sign fill versus zero fill
      send(4'd7, 64'h8000_0000_8000_0000, 64'd4, 64'd0, 6'd0, "R5");
      send(4'd8, 64'h8000_0000_8000_0000, 64'd4, 64'd0, 6'd0, "R5");
      send(4'd8, 64'h8000_0000_8000_0000, 64'd36, 64'd0, 6'd0, "R5");
      idle(2);
      // R6/R7: immediate shifts with bit 5 of the field set
      send(4'd9,  64'h0000_0000_0000_00FF, 64'd0, 64'd0, 6'd33, "R7");
      send(4'd9,  64'h0000_0000_0000_00FF, 64'd0, 64'd0, 6'd31, "R6");
      send(4'd10, 64'hF000_0000_F000_0000, 64'd0, 64'd0, 6'd33, "R7");
      send(4'd11, 64'h8000_0000_8000_0000, 64'd0, 64'd0, 6'd63, "R6");
      // R8/R9/R10: word ops (legal wide, illegal narrow)
      send(4'd12, 64'hDEAD_0000_7FFF_FFFF, 64'h1234_0000_0000_0001, 64'd0, 6'd0, "R8");
      send(4'd13, 64'h5555_0000_0000_0000, 64'h0000_0001_0000_0001, 64'd0, 6'd0, "R8");
      send(4'd14, 64'h0000_0001_0000_0005, 64'd0, 64'hFFFF_FFFF_FFFF_FFFA, 6'd0, "R9");
      send(4'd14, 64'hFFFF_FFFF_7FFF_FFFF, 64'd0, 64'd1, 6'd0, "R10");
      // R11: reserved code
      send(4'd15, 64'h1, 64'h2, 64'h3, 6'd4, "R11");
      idle(3);

      // Mixed stream with gaps
      for (int i = 0; i < 400; i++) begin
         send(4'($urandom % 16), {$urandom, $urandom}, {$urandom, $urandom},
              {$urandom, $urandom}, 6'($urandom % 64), "");
         if (($urandom % 4) == 0) idle(1 + ($urandom % 3));
      end
      idle(4);

      // R1: every request produced exactly one strobe
      checks++;
      if (q64.size() != 0 || q32.size() != 0) begin
         errors++;
         $display("FAIL R1: actual pending=%0d/%0d expected 0/0", q64.size(), q32.size());
      end
      finish_run();
   end

endmodule